// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block lets a fixed group of participants meet at a common point before any of them goes on. Each participant signals arrival with a one-cycle pulse. It is then held until every member of the group has arrived. Once the group is complete, all participants are let go together, and the barrier is ready for the next round at once. No clear cycle or idle gap is needed between rounds.

The unit keeps one arrival count and one shared release flag. Each participant also has a private sense bit, which flips every time that participant enters. A participant is held while its sense bit equals the release flag. The arrival that completes the group clears the count and inverts the flag, which frees everyone at once. The new flag value is the complement of the completing arriver's new sense. The flag is only ever inverted, never cleared and then set. So a fast participant that re-enters right after release is simply held for the next round. It cannot wipe out the release that a slower participant has not yet observed.

Arrivals from several participants in the same cycle are all counted in that cycle. A pulse from a participant that is already held is a protocol breach. It is not counted, and it sets a sticky error output.

Top module: `sense_barrier`

## Requirements
- R1: After reset every hold output is low and the error output is low. Internally the release flag is 0 and every sense bit is 1.
- R2: An arrive pulse (arrive bit i high for one cycle) from a participant whose hold is low sets hold bit i high in the next cycle, unless that pulse completes the group.
- R3: Arrive pulses from several free participants in one cycle are all counted in that cycle, and each of their hold bits goes high together in the next cycle.
- R4: When the free participants arriving in a cycle, together with those already held, make up all N participants, every hold output is low in the next cycle and the arrival count restarts from zero.
- R5: An arrive pulse from a participant whose hold is high is not counted and does not change any hold output. It sets the error output high in the next cycle.
- R6: Once the error output is high, it stays high until reset.
- R7: A participant released by a completed round can arrive again in the very next cycle. It is then held for the new round, and the rounds repeat without deadlock.
- R8: The number of held participants always equals the arrival count and never reaches N, so the hold outputs are never all high at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_i | input | N_PARTS | One-cycle arrival pulse per participant |
| hold_o | output | N_PARTS | High while the participant must wait |
| err_o | output | 1 | Sticky flag for an arrival from an already held participant |

## Verification
The assertions assume that arrive pulses are sampled only on clock edges and that each participant's pulse lasts one cycle per entry. A pulse from a held participant is legal input, but it is treated as a breach. From these assumptions the assertions derive that the count never overflows and always matches the number of held participants. The stimulus drives each arrival vector for exactly one cycle, 5 ns after a rising edge. It then clears the vector, so every pulse is a single sample. Some sweep cases deliberately pulse participants that are already held, in order to exercise the ignore-and-flag path.

// File: rtl/sbar_pkg.sv
package sbar_pkg;

    // Number of set bits in a vector of up to 64 participants
    function automatic int unsigned ones64(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n = n + 32'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/sbar_sense_bank.sv
module sbar_sense_bank #(
    parameter int N_PARTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PARTS-1:0] arrive_i,
    input  logic               flag_i,
    input  logic               done_i,
    output logic [N_PARTS-1:0] accept_o,
    output logic [N_PARTS-1:0] stray_o,
    output logic [N_PARTS-1:0] hold_o
);

    typedef struct packed {
        logic [N_PARTS-1:0] sense;
    } bank_t;

    bank_t bank_d, bank_q;

    // Per-participant wait decision: held while sense matches the flag
    for (genvar g = 0; g < N_PARTS; g++) begin : g_part
        assign hold_o[g]   = (bank_q.sense[g] == flag_i);
        assign accept_o[g] = arrive_i[g] & ~hold_o[g];
        assign stray_o[g]  = arrive_i[g] &  hold_o[g];
    end

    always_comb begin
        bank_d       = bank_q;
        bank_d.sense = bank_q.sense ^ accept_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.sense <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    // A free arriver that does not complete the round is held next cycle
    AST_ARRIVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|accept_o) && !done_i |=> ((hold_o & $past(accept_o)) == $past(accept_o))); // R2
    // Held participants keep their sense when they pulse again
    AST_STRAY_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|stray_o) && !done_i |=> ((hold_o & $past(stray_o)) == $past(stray_o))); // R5

endmodule

// File: rtl/sbar_arrival_counter.sv
module sbar_arrival_counter #(
    parameter int N_PARTS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N_PARTS-1:0]                 accept_i,
    output logic                               flag_o,
    output logic                               done_o,
    output logic [$clog2(N_PARTS+1)-1:0]       count_o
);
    import sbar_pkg::*;

    localparam int CNT_W = $clog2(N_PARTS + 1);
    localparam logic [CNT_W:0] FULL = (CNT_W + 1)'(N_PARTS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [CNT_W-1:0] pop;
    logic [CNT_W:0]   total;

    always_comb begin
        pop    = CNT_W'(ones64(64'(accept_i)));
        total  = {1'b0, ctr_q.cnt} + {1'b0, pop};
        done_o = (total == FULL);
        ctr_d  = ctr_q;
        if (done_o) begin
            ctr_d.cnt  = '0;
            ctr_d.flag = ~ctr_q.flag;
        end else begin
            ctr_d.cnt  = total[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.cnt  <= '0;
            ctr_q.flag <= 1'b0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign flag_o  = ctr_q.flag;
    assign count_o = ctr_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        total <= FULL); // R8
    AST_FLAG_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (flag_o != $past(flag_o)) && (count_o == '0)); // R4
    AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> $stable(flag_o)); // R7

endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
    parameter int N_PARTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PARTS-1:0] arrive_i,
    output logic [N_PARTS-1:0] hold_o,
    output logic               err_o
);

    localparam int CNT_W = $clog2(N_PARTS + 1);

    typedef struct packed {
        logic err;
    } top_t;

    top_t top_d, top_q;

    logic [N_PARTS-1:0] accept;
    logic [N_PARTS-1:0] stray;
    logic               flag;
    logic               done;
    logic [CNT_W-1:0]   count;

    sbar_sense_bank #(.N_PARTS(N_PARTS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive_i (arrive_i),
        .flag_i   (flag),
        .done_i   (done),
        .accept_o (accept),
        .stray_o  (stray),
        .hold_o   (hold_o)
    );

    sbar_arrival_counter #(.N_PARTS(N_PARTS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .flag_o   (flag),
        .done_o   (done),
        .count_o  (count)
    );

    always_comb begin
        top_d     = top_q;
        top_d.err = top_q.err | (|stray);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.err <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    assign err_o = top_q.err;

    AST_ALL_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (hold_o == '0)); // R4
    AST_COUNT_MATCHES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) == $countones(hold_o)); // R8
    AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (|stray) |=> err_o); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R6

endmodule

// File: tb/tb_sense_barrier.sv
module tb_sense_barrier;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] arrive = '0;
    logic [N-1:0] hold_o;
    logic         err_o;

    logic [N-1:0] exp_hold;
    logic         exp_err;
    int           n_run = 0;
    int           n_fail = 0;
    bit           ended = 0;

    always #10 clk = ~clk;

    sense_barrier #(.N_PARTS(N)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive_i (arrive),
        .hold_o   (hold_o),
        .err_o    (err_o)
    );

    function automatic int cnt1(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        arrive = '0;
        repeat (2) @(posedge clk);
        #5 rst_n = 1'b1;
        exp_hold = '0;
        exp_err  = 1'b0;
        check("R1 hold", hold_o, '0);
        check("R1 err", N'(err_o), '0);
    endtask

    // Drive one arrival vector for one cycle and compare against the model
    task automatic step(input logic [N-1:0] a, input string force_tag);
        logic [N-1:0] acc, st;
        string tag;
        bit complete;
        acc = a & ~exp_hold;
        st  = a & exp_hold;
        complete = (cnt1(exp_hold | acc) == N);
        if (force_tag != "")      tag = force_tag;
        else if (st != '0)        tag = "R5";
        else if (complete)        tag = "R4";
        else if (cnt1(acc) > 1)   tag = "R3";
        else                      tag = "R2";
        arrive = a;
        @(posedge clk);
        #5 arrive = '0;
        if (complete) exp_hold = '0;
        else          exp_hold = exp_hold | acc;
        if (st != '0) exp_err = 1'b1;
        check({tag, " hold"}, hold_o, exp_hold);
        check({tag, " err"}, N'(err_o), N'(exp_err));
        n_run++;
        if (hold_o === '1) begin
            n_fail++;
            $display("FAIL R8 actual=%b expected=not all ones", hold_o);
        end
    endtask

    initial begin
        // Near-exhaustive sweep: every pair of arrival vectors, then drain
        for (int x = 0; x < (1 << N); x++) begin
            for (int y = 0; y < (1 << N); y++) begin
                do_reset();
                step(N'(x), "");
                step(N'(y), "");
                if (exp_err) begin
                    step('0, "R6");
                end
                step(~exp_hold, "");
                check("R4 drained", hold_o, '0);
            end
        end

        // Back-to-back rounds with a fast participant re-entering at once
        do_reset();
        for (int r = 0; r < 6; r++) begin
            step(N'(1), "R7");
            for (int p = 1; p < N; p++) begin
                step(N'(1) << p, "R7");
            end
            check("R7 round end", hold_o, '0);
        end

        // Whole group in one cycle, repeated
        for (int r = 0; r < 3; r++) begin
            step('1, "R3");
        end

        // Sticky error after idle cycles
        step(N'(2), "R2");
        step(N'(2), "R5");
        repeat (4) step('0, "R6");

        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule